// File: doc/BRIEF.md
# Three-Wire Configuration Word Loader

This block receives 24-bit configuration words for a dual-channel frequency synthesizer over a slow three-wire link: a serial data line, a serial clock and a latch-enable line. All three wires are brought into the system clock domain through two-flop synchronisers. Each rising edge of the synchronised serial clock shifts one data bit into a shift register, most significant bit first. When latch enable rises, the word is copied into one of four destination registers. The two control bits at the bottom of the word pick the destination.

The four destinations are a reference-divider register and a main/swallow-divider register for each of the two channels (called IF and RF). A reference word carries a 14-bit reference divide value, two test bits and one charge-pump current-select bit. A main/swallow word carries an 11-bit N value and a 7-bit A value. Every write pulses that destination's update strobe for one system clock cycle.

The loader is a three-state machine:
- ST_SHIFT: accepts serial bits.
- ST_COMMIT: lasts one cycle and writes the word.
- ST_HOLD: waits for latch enable to drop.

The transitions are:
- ST_SHIFT to ST_COMMIT on a detected latch-enable rise.
- ST_COMMIT to ST_HOLD if latch enable is still high.
- ST_COMMIT to ST_SHIFT if latch enable is already low.
- ST_HOLD to ST_SHIFT when the synchronised latch enable reads low.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset all field outputs and all four update strobes are zero.
- R2: The word is the last 24 bits sampled on serial-clock rising edges, first bit sent being word bit 23. Bits sent earlier than those 24 have no effect.
- R3: The control field word[1:0] selects the destination: 0 is IF reference, 1 is RF reference, 2 is IF main/swallow, 3 is RF main/swallow. A latch leaves the other three registers unchanged.
- R4: Reference word layout: the divide value is word[15:2], the test bits are word[17:16], the current-select bit is word[18], and word[23:19] are dummy bits with no effect.
- R5: Main/swallow word layout: A is word[8:2], N is word[19:9], and word[23:20] are dummy bits with no effect.
- R6: A reference word whose divide value is below 3 is rejected. The register keeps its value and no strobe fires. A value of 3 or more, up to 16383, is accepted.
- R7: An accepted latch pulses upd_stb[code] high for exactly one cycle, where code is the control-field value. At most one strobe bit is high at a time. The strobe and the new register value appear together on the third clk rising edge after the first edge that samples ser_le high.
- R8: Serial bits clocked in while latch enable is high are ignored. A later latch with no new bits writes the same word again.
- R9: Each latch-enable rise gives exactly one write, however long latch enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; a rising edge commits the word |
| if_ref_div | output | 14 | IF reference divide value |
| if_ref_test | output | 2 | IF reference test bits |
| if_ref_cs | output | 1 | IF charge-pump current select |
| rf_ref_div | output | 14 | RF reference divide value |
| rf_ref_test | output | 2 | RF reference test bits |
| rf_ref_cs | output | 1 | RF charge-pump current select |
| if_n | output | 11 | IF main counter value N |
| if_a | output | 7 | IF swallow counter value A |
| rf_n | output | 11 | RF main counter value N |
| rf_a | output | 7 | RF swallow counter value A |
| upd_stb | output | 4 | One-cycle write strobes, indexed by control code |

## Verification
The assertions check on every cycle that:
- the strobes are one-hot or idle and last a single cycle;
- a register changes only in the cycle its own strobe is high;
- no reference register ever takes a divide value below 3;
- the shift register stays frozen whenever the machine is outside ST_SHIFT.

Other behaviours only the bench's scenarios can show, because they depend on what was sent on the serial line. These are:
- the MSB-first bit order and the discarding of surplus leading bits;
- the exact field positions and destination routing;
- the three-cycle latch latency;
- re-latching a stored word after bits were ignored under a high latch enable.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    // Loader sequencing states
    typedef enum logic [1:0] {
        ST_SHIFT  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } ld_state_e;

    // Destination codes carried in the control field
    typedef enum logic [1:0] {
        DST_IF_REF = 2'd0,
        DST_RF_REF = 2'd1,
        DST_IF_DIV = 2'd2,
        DST_RF_DIV = 2'd3
    } dest_e;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_q
);
    // MSB-first: older bits move up; bits past the top fall off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= {word_q[W-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_dest_bank.sv
module cfg_dest_bank #(
    parameter int NDEST = 4,
    parameter int REG_W = 18,
    localparam int SEL_W = $clog2(NDEST)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [REG_W-1:0]             wr_data,
    output logic [NDEST-1:0][REG_W-1:0]  regs_q,
    output logic [NDEST-1:0]             stb_q
);
    for (genvar g = 0; g < NDEST; g++) begin : g_slot
        logic [REG_W-1:0] slot_q;
        logic             hit;
        logic             slot_stb_q;

        assign hit = wr_en && (wr_sel == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q     <= '0;
                slot_stb_q <= 1'b0;
            end else begin
                slot_stb_q <= hit;
                if (hit) slot_q <= wr_data;
            end
        end

        assign regs_q[g] = slot_q;
        assign stb_q[g]  = slot_stb_q;
    end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CTRL_W      = 2,
    parameter int REF_DIV_W   = 14,
    parameter int REF_TEST_W  = 2,
    parameter int N_W         = 11,
    parameter int A_W         = 7,
    parameter int REF_DIV_MIN = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_data,
    input  logic                  ser_le,
    output logic [REF_DIV_W-1:0]  if_ref_div,
    output logic [REF_TEST_W-1:0] if_ref_test,
    output logic                  if_ref_cs,
    output logic [REF_DIV_W-1:0]  rf_ref_div,
    output logic [REF_TEST_W-1:0] rf_ref_test,
    output logic                  rf_ref_cs,
    output logic [N_W-1:0]        if_n,
    output logic [A_W-1:0]        if_a,
    output logic [N_W-1:0]        rf_n,
    output logic [A_W-1:0]        rf_a,
    output logic [3:0]            upd_stb
);
    localparam int NDEST  = 1 << CTRL_W;
    localparam int REF_W  = REF_DIV_W + REF_TEST_W + 1;
    localparam int DIV_W  = N_W + A_W;
    localparam int REG_W  = (REF_W > DIV_W) ? REF_W : DIV_W;
    localparam int KEEP_W = CTRL_W + REG_W;

    // Synchronised wires
    logic [2:0] sy_q;
    logic       sclk_s, sdat_s, le_s;
    logic       sclk_d, le_d;
    logic       sclk_rise, le_rise;

    cfg_sync2 #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_data, ser_le}),
        .q     (sy_q)
    );

    assign sclk_s = sy_q[2];
    assign sdat_s = sy_q[1];
    assign le_s   = sy_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = le_s & ~le_d;

    // Shift register (upper dummy bits shift out the top)
    logic              shift_en;
    logic [KEEP_W-1:0] shreg_q;

    cfg_shifter #(.W(KEEP_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (sdat_s),
        .word_q   (shreg_q)
    );

    // Word decode
    logic [CTRL_W-1:0]    dest_sel;
    logic [REG_W-1:0]     payload;
    logic                 is_ref;
    logic                 word_ok;

    assign dest_sel = shreg_q[CTRL_W-1:0];
    assign payload  = shreg_q[KEEP_W-1:CTRL_W];
    assign is_ref   = (dest_sel < CTRL_W'(2));
    assign word_ok  = !is_ref || (payload[REF_DIV_W-1:0] >= REF_DIV_W'(REF_DIV_MIN));

    // State machine
    ld_state_e state_q, state_d;
    logic      wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHIFT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT:  if (le_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = le_s ? ST_HOLD : ST_SHIFT;
            ST_HOLD:   if (!le_s) state_d = ST_SHIFT;
            default:   state_d = ST_SHIFT;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            ST_SHIFT:  shift_en = sclk_rise;
            ST_COMMIT: wr_en    = word_ok;
            ST_HOLD:   ;
            default:   ;
        endcase
    end

    // Destination registers
    logic [NDEST-1:0][REG_W-1:0] regs_q;
    logic [NDEST-1:0]            stb_q;

    cfg_dest_bank #(.NDEST(NDEST), .REG_W(REG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (dest_sel),
        .wr_data (payload),
        .regs_q  (regs_q),
        .stb_q   (stb_q)
    );

    assign if_ref_div  = regs_q[DST_IF_REF][REF_DIV_W-1:0];
    assign if_ref_test = regs_q[DST_IF_REF][REF_DIV_W +: REF_TEST_W];
    assign if_ref_cs   = regs_q[DST_IF_REF][REF_DIV_W+REF_TEST_W];
    assign rf_ref_div  = regs_q[DST_RF_REF][REF_DIV_W-1:0];
    assign rf_ref_test = regs_q[DST_RF_REF][REF_DIV_W +: REF_TEST_W];
    assign rf_ref_cs   = regs_q[DST_RF_REF][REF_DIV_W+REF_TEST_W];
    assign if_a        = regs_q[DST_IF_DIV][A_W-1:0];
    assign if_n        = regs_q[DST_IF_DIV][A_W +: N_W];
    assign rf_a        = regs_q[DST_RF_DIV][A_W-1:0];
    assign rf_n        = regs_q[DST_RF_DIV][A_W +: N_W];
    assign upd_stb     = stb_q[3:0];

    // Reference slots are wider than their fields; the spare bits are unused
    if (REG_W > REF_W) begin : g_spare
        logic unused_ref_spare;
        assign unused_ref_spare = ^{regs_q[DST_IF_REF][REG_W-1:REF_W],
                                    regs_q[DST_RF_REF][REG_W-1:REF_W]};
    end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
    import cfg_loader_pkg::*;
#(
    parameter int KEEP_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input ld_state_e         state_q,
    input logic [KEEP_W-1:0] shreg_q,
    input logic [3:0]        upd_stb,
    input logic [13:0]       if_ref_div,
    input logic [16:0]       if_ref_all,
    input logic [13:0]       rf_ref_div,
    input logic [16:0]       rf_ref_all,
    input logic [17:0]       if_div_all,
    input logic [17:0]       rf_div_all
);
    // R7
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_stb));

    // R7
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_stb) |=> (upd_stb == 4'b0000));

    // R6
    if_ref_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb[0] |-> (if_ref_div >= 14'd3));

    // R6
    rf_ref_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb[1] |-> (rf_ref_div >= 14'd3));

    // R3
    if_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb[0] |-> $stable(if_ref_all));

    // R3
    rf_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb[1] |-> $stable(rf_ref_all));

    // R3
    if_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb[2] |-> $stable(if_div_all));

    // R3
    rf_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb[3] |-> $stable(rf_div_all));

    // R8
    frozen_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |=> $stable(shreg_q));
endmodule

bind serial_cfg_loader cfg_loader_chk #(.KEEP_W(KEEP_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .shreg_q    (shreg_q),
    .upd_stb    (upd_stb),
    .if_ref_div (if_ref_div),
    .if_ref_all ({if_ref_cs, if_ref_test, if_ref_div}),
    .rf_ref_div (rf_ref_div),
    .rf_ref_all ({rf_ref_cs, rf_ref_test, rf_ref_div}),
    .if_div_all ({if_n, if_a}),
    .rf_div_all ({rf_n, rf_a})
);

// File: tb/serial_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] if_ref_div, rf_ref_div;
    logic [1:0]  if_ref_test, rf_ref_test;
    logic        if_ref_cs, rf_ref_cs;
    logic [10:0] if_n, rf_n;
    logic [6:0]  if_a, rf_a;
    logic [3:0]  upd_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int stb_cnt [4];

    always #2.5 clk = ~clk;

    serial_cfg_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .if_ref_div(if_ref_div), .if_ref_test(if_ref_test), .if_ref_cs(if_ref_cs),
        .rf_ref_div(rf_ref_div), .rf_ref_test(rf_ref_test), .rf_ref_cs(rf_ref_cs),
        .if_n(if_n), .if_a(if_a), .rf_n(rf_n), .rf_a(rf_a), .upd_stb(upd_stb)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model: input histories sampled each edge
    logic [4:0]  le_h, sc_h, dt_h;
    logic [19:0] m_sh;
    logic [16:0] e_ref [2];
    logic [17:0] e_div [2];
    logic [3:0]  e_stb;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            le_h = '0; sc_h = '0; dt_h = '0; m_sh = '0;
            e_ref[0] = '0; e_ref[1] = '0; e_div[0] = '0; e_div[1] = '0;
            e_stb = '0;
        end else begin
            le_h = {le_h[3:0], ser_le};
            sc_h = {sc_h[3:0], ser_clk};
            dt_h = {dt_h[3:0], ser_data};
            e_stb = '0;
            if (le_h[3] && !le_h[4]) begin
                if (m_sh[1:0] < 2) begin
                    if (m_sh[15:2] >= 3) begin
                        e_ref[m_sh[1:0]] = m_sh[18:2];
                        e_stb[m_sh[1:0]] = 1'b1;
                    end
                end else begin
                    e_div[m_sh[0]] = m_sh[19:2];
                    e_stb[m_sh[1:0]] = 1'b1;
                end
            end
            if (sc_h[2] && !sc_h[3] && !le_h[2])
                m_sh = {m_sh[18:0], dt_h[2]};
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 strobe", upd_stb, e_stb);
            check("R4 if_ref", {if_ref_cs, if_ref_test, if_ref_div}, e_ref[0]);
            check("R4 rf_ref", {rf_ref_cs, rf_ref_test, rf_ref_div}, e_ref[1]);
            check("R5 if_div", {if_n, if_a}, e_div[0]);
            check("R5 rf_div", {rf_n, rf_a}, e_div[1]);
            for (int i = 0; i < 4; i++) if (upd_stb[i]) stb_cnt[i]++;
        end
    end

    function automatic logic [23:0] mk_ref(logic [1:0] c, int r, int t, bit cs, logic [4:0] x);
        logic [13:0] rr = r[13:0];
        logic [1:0]  tt = t[1:0];
        return {x, cs, tt, rr, c};
    endfunction

    function automatic logic [23:0] mk_div(logic [1:0] c, int n, int a, logic [3:0] x);
        logic [10:0] nn = n[10:0];
        logic [6:0]  aa = a[6:0];
        return {x, nn, aa, c};
    endfunction

    task automatic send_bits(logic [31:0] w, int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk) ser_data = w[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_le(int hold);
        @(negedge clk) ser_le = 1'b1;
        repeat (hold) @(negedge clk);
        ser_le = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic load(logic [23:0] w);
        send_bits({8'h00, w}, 24);
        pulse_le(8);
    endtask

    initial begin
        int c0;
        for (int i = 0; i < 4; i++) stb_cnt[i] = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 if_ref", {if_ref_cs, if_ref_test, if_ref_div}, 0);
        check("R1 rf_div", {rf_n, rf_a}, 0);
        check("R1 strobes", upd_stb, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 IF reference word with dummies set
        load(mk_ref(2'd0, 1000, 2, 1'b1, 5'b10101));
        check("R4 if_ref_div", if_ref_div, 1000);
        check("R4 if_ref_test", if_ref_test, 2);
        check("R4 if_ref_cs", if_ref_cs, 1);
        check("R3 rf_ref untouched", rf_ref_div, 0);
        check("R7 if_ref strobe count", stb_cnt[0], 1);

        // R4 RF reference at top of range
        load(mk_ref(2'd1, 16383, 1, 1'b0, 5'b00000));
        check("R4 rf_ref_div max", rf_ref_div, 16383);
        check("R3 if_ref unchanged", if_ref_div, 1000);

        // R5 IF main/swallow at maxima
        load(mk_div(2'd2, 2047, 127, 4'hF));
        check("R5 if_n", if_n, 2047);
        check("R5 if_a", if_a, 127);
        check("R7 if_div strobe count", stb_cnt[2], 1);

        // R5 RF main/swallow low values
        load(mk_div(2'd3, 3, 0, 4'h0));
        check("R5 rf_n", rf_n, 3);
        check("R5 rf_a", rf_a, 0);

        // R6 divide value 2 rejected, 3 accepted
        c0 = stb_cnt[0];
        load(mk_ref(2'd0, 2, 3, 1'b0, 5'b0));
        check("R6 rejected keeps value", if_ref_div, 1000);
        check("R6 rejected no strobe", stb_cnt[0], c0);
        load(mk_ref(2'd0, 3, 0, 1'b0, 5'b0));
        check("R6 minimum accepted", if_ref_div, 3);
        check("R6 minimum strobe", stb_cnt[0], c0 + 1);

        // R2 surplus leading bits discarded, MSB first
        send_bits({4'hA, 4'h5, mk_div(2'd2, 1234, 77, 4'h3)}, 32);
        pulse_le(8);
        check("R2 if_n after surplus bits", if_n, 1234);
        check("R2 if_a after surplus bits", if_a, 77);

        // R8 bits during high LE ignored, then re-latch of same word
        load(mk_div(2'd3, 100, 5, 4'h0));
        c0 = stb_cnt[3];
        @(negedge clk) ser_le = 1'b1;
        repeat (8) @(negedge clk);
        send_bits(32'h000000FF, 8);
        ser_le = 1'b0;
        repeat (10) @(negedge clk);
        pulse_le(8);
        check("R8 rf_n after ignored bits", rf_n, 100);
        check("R8 rf_a after ignored bits", rf_a, 5);
        check("R8 relatch strobes", stb_cnt[3], c0 + 2);

        // R9 long latch enable gives one write
        c0 = stb_cnt[1];
        send_bits({8'h00, mk_ref(2'd1, 77, 0, 1'b1, 5'b0)}, 24);
        pulse_le(200);
        check("R9 single strobe", stb_cnt[1], c0 + 1);
        check("R9 rf_ref value", rf_ref_div, 77);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule